// File: doc/BRIEF.md
# Quantizing Paired Load/Store Converter

This block is a pipeline stage in a load/store path. It sits between the data returned by a cache and a floating-point register file whose registers each hold a pair of single-precision values. It converts between compact integer memory formats and those register pairs. A load takes one or two packed integers, each 8 or 16 bits wide and either signed or unsigned. It scales each by a power of two and returns exact IEEE-754 single-precision values. A store takes one or two single-precision values, scales them, truncates them toward zero and saturates them into the chosen integer type. The result is packed memory data that is 2:1 (16-bit) or 4:1 (8-bit) smaller than the float form.

Requests enter through a valid/ready handshake and leave through a second one. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. A response is consumed on an edge where `rsp_valid` and `rsp_ready` are both high. While a response waits for `rsp_ready`, it and every field beside it stay unchanged. The two internal stages then fill, and `req_ready` falls only when both stages are full and `rsp_ready` is low. Nothing is dropped or duplicated under back-pressure.

The type field `req_kind` uses bit 1 for width (1 = 16-bit, 0 = 8-bit) and bit 0 for signedness (1 = two's complement). `req_scale` is a 6-bit two's-complement exponent s in -32..31.

Top module: `qps_convert`

## Requirements
- R1: A response held with `rsp_ready` low keeps `rsp_valid` high and all response fields unchanged until it is consumed. `req_ready` is high whenever `rsp_ready` is high, so one request per cycle is accepted, and every accepted request yields exactly one response, in order.
- R2: A request accepted on edge k is presented and can be consumed on edge k+2 when `rsp_ready` is high at edges k+1 and k+2.
- R3: A load converts each integer element v, taken according to `req_kind`, into the exact single-precision value v·2^-s. The sign is negative only for negative signed elements.
- R4: A zero element loads as +0.0 (all bits zero) for every scale and type.
- R5: Element 0 is the lower memory lane: bits [7:0] for 8-bit or [15:0] for 16-bit. Element 1 is the next lane: [15:8] or [31:16]. Element 0 maps to `rsp_fp0` and `req_fp0`, and element 1 maps to `rsp_fp1` and `req_fp1`.
- R6: With `req_pair` low, only element 0 is converted. A load returns `rsp_fp1` = 0x3F800000 (+1.0). A store drives all `rsp_mem` bits above element 0 to zero.
- R7: A store computes x·2^s and truncates toward zero (for example, -2.75 becomes -2).
- R8: A store saturates to the type range: s8 -128..127, u8 0..255, s16 -32768..32767, u16 0..65535. Negative values give 0 for unsigned types. ±infinity gives the type's maximum or minimum.
- R9: A store of a NaN gives 0. A store of ±0.0 or of a denormal input (exponent field zero) gives 0.
- R10: `rsp_bytes` equals the element size (1 or 2) times the element count (2 when paired, else 1).
- R11: Load responses drive `rsp_mem` to zero. Store responses drive `rsp_fp0` and `rsp_fp1` to zero. `rsp_store` echoes the request direction.
- R12: During and right after reset, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be taken |
| req_store | input | 1 | 1 = store (float to integer), 0 = load |
| req_kind | input | 2 | bit1 = 16-bit width, bit0 = signed |
| req_scale | input | 6 | Two's-complement scale exponent |
| req_pair | input | 1 | 1 = two elements, 0 = one |
| req_mem | input | 32 | Packed integers for a load |
| req_fp0 | input | 32 | Slot 0 single for a store |
| req_fp1 | input | 32 | Slot 1 single for a store |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response can be taken |
| rsp_store | output | 1 | Direction of this response |
| rsp_bytes | output | 3 | Packed memory size in bytes |
| rsp_fp0 | output | 32 | Slot 0 single from a load |
| rsp_fp1 | output | 32 | Slot 1 single from a load |
| rsp_mem | output | 32 | Packed integers from a store |

## Verification
The assertions check four things on every cycle:
- A stalled response holds steady.
- `req_ready` never drops while `rsp_ready` is high.
- An accepted request reaches the output one edge after a free second stage.
- The size code is a legal power of two, and the unused half of each response is zero.

The numeric behaviour can only be shown by the bench's scenarios comparing against an independent arithmetic model. That behaviour covers exact scaling, truncation toward zero, saturation bounds, NaN, infinity and denormal handling, lane order and the single-mode fill value. The same holds for in-order, loss-free delivery under random back-pressure.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int FP_W     = 32;
  localparam int MANT_W   = 23;
  localparam int EXP_BIAS = 127;
  localparam int ELEM_W   = 16;
  localparam int HALF_W   = ELEM_W / 2;
  localparam int LANES    = 2;
  localparam int MEM_W    = LANES * ELEM_W;
  localparam int SCALE_W  = 6;
  localparam int BYTES_W  = $clog2(LANES * ELEM_W / 8) + 1;
  localparam logic [FP_W-1:0] FP_ONE = 32'h3F80_0000;

  typedef struct packed {
    logic                    store;
    logic                    wide;
    logic                    sgn;
    logic                    pair;
    logic [SCALE_W-1:0]      scale;
    logic [MEM_W-1:0]        mem;
    logic [LANES*FP_W-1:0]   fp;
  } qps_req_t;
endpackage

// File: rtl/qps_int2fp.sv
module qps_int2fp
  import qps_pkg::*;
(
  input  logic [ELEM_W-1:0]         raw,
  input  logic                      wide,
  input  logic                      sgn,
  input  logic signed [SCALE_W-1:0] scale,
  output logic [FP_W-1:0]           fp
);
  logic                     neg;
  logic [ELEM_W-1:0]        ext8;
  logic [ELEM_W-1:0]        mag;
  int                       msb;
  logic [ELEM_W+MANT_W-1:0] sh;
  logic [9:0]               expv;

  always_comb begin
    ext8 = {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]};
    if (wide) begin
      neg = sgn & raw[ELEM_W-1];
      mag = neg ? (~raw + 1'b1) : raw;
    end else begin
      neg = sgn & raw[HALF_W-1];
      mag = neg ? (~ext8 + 1'b1) : {{HALF_W{1'b0}}, raw[HALF_W-1:0]};
    end
    // leading one position of the magnitude
    msb = 0;
    for (int i = 0; i < ELEM_W; i++) begin
      if (mag[i]) msb = i;
    end
    sh   = (ELEM_W+MANT_W)'(mag) << (MANT_W - msb);
    expv = 10'(EXP_BIAS + msb - int'(scale));
    fp   = (mag == '0) ? '0 : {neg, expv[7:0], sh[MANT_W-1:0]};
  end
endmodule

// File: rtl/qps_fp2int.sv
module qps_fp2int
  import qps_pkg::*;
(
  input  logic [FP_W-1:0]           fp,
  input  logic                      wide,
  input  logic                      sgn,
  input  logic signed [SCALE_W-1:0] scale,
  output logic [ELEM_W-1:0]         val
);
  logic [7:0]        e;
  logic [MANT_W-1:0] frac;
  logic              neg, nan, inf, zero, sat, tiny;
  logic [MANT_W:0]   sig;
  logic [ELEM_W-1:0] mag;
  logic [ELEM_W-1:0] res;
  int                ue, shamt, w, pmax, nlim, v;

  always_comb begin
    e     = fp[FP_W-2:MANT_W];
    frac  = fp[MANT_W-1:0];
    neg   = fp[FP_W-1];
    ue    = int'(e) - EXP_BIAS + int'(scale);
    nan   = (e == 8'hFF) && (frac != '0);
    inf   = (e == 8'hFF) && (frac == '0);
    zero  = (e == 8'h00);
    // at or beyond 2^ELEM_W every integer type is exceeded
    sat   = inf || (!zero && !nan && ue >= ELEM_W);
    tiny  = zero || (ue < 0);
    sig   = {1'b1, frac};
    shamt = (ue >= 0 && ue < ELEM_W) ? (MANT_W - ue) : MANT_W;
    mag   = (sat || tiny) ? '0 : ELEM_W'(sig >> shamt);
    w     = wide ? ELEM_W : HALF_W;
    pmax  = sgn ? ((1 << (w - 1)) - 1) : ((1 << w) - 1);
    nlim  = 1 << (w - 1);
    if (nan) begin
      v = 0;
    end else if (neg) begin
      if (!sgn)                            v = 0;
      else if (sat || int'(mag) > nlim)    v = -nlim;
      else                                 v = -int'(mag);
    end else begin
      if (sat || int'(mag) > pmax)         v = pmax;
      else                                 v = int'(mag);
    end
    res = ELEM_W'(v);
    val = wide ? res : {{HALF_W{1'b0}}, res[HALF_W-1:0]};
  end
endmodule

// File: rtl/qps_convert.sv
module qps_convert
  import qps_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_store,
  input  logic [1:0]         req_kind,
  input  logic [SCALE_W-1:0] req_scale,
  input  logic               req_pair,
  input  logic [MEM_W-1:0]   req_mem,
  input  logic [FP_W-1:0]    req_fp0,
  input  logic [FP_W-1:0]    req_fp1,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_store,
  output logic [BYTES_W-1:0] rsp_bytes,
  output logic [FP_W-1:0]    rsp_fp0,
  output logic [FP_W-1:0]    rsp_fp1,
  output logic [MEM_W-1:0]   rsp_mem
);
  qps_req_t req_in, s1_q;
  logic     s1_v, s2_v, s1_rdy, s2_rdy;
  logic signed [SCALE_W-1:0] s1_scale;

  logic [FP_W-1:0]   ld_fp [LANES];
  logic [ELEM_W-1:0] st_el [LANES];
  logic [LANES*FP_W-1:0] fp_pk;
  logic [MEM_W-1:0]      mem_pk;
  logic [BYTES_W-1:0]    bytes_c;

  logic                  s2_store;
  logic [BYTES_W-1:0]    s2_bytes;
  logic [LANES*FP_W-1:0] s2_fp;
  logic [MEM_W-1:0]      s2_mem;

  assign req_in = '{store: req_store, wide: req_kind[1], sgn: req_kind[0],
                    pair: req_pair, scale: req_scale, mem: req_mem,
                    fp: {req_fp1, req_fp0}};

  // handshake: a stage may load when it is empty or its successor moves
  assign s2_rdy    = !s2_v || rsp_ready;
  assign s1_rdy    = !s1_v || s2_rdy;
  assign req_ready = s1_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_q <= '0;
    end else if (s1_rdy) begin
      s1_v <= req_valid;
      if (req_valid) s1_q <= req_in;
    end
  end

  assign s1_scale = s1_q.scale;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ELEM_W-1:0] raw;
    logic [FP_W-1:0]   ld_cvt;
    logic [ELEM_W-1:0] st_cvt;

    assign raw = s1_q.wide ? s1_q.mem[l*ELEM_W +: ELEM_W]
                           : {{HALF_W{1'b0}}, s1_q.mem[l*HALF_W +: HALF_W]};

    qps_int2fp u_ld (
      .raw  (raw),
      .wide (s1_q.wide),
      .sgn  (s1_q.sgn),
      .scale(s1_scale),
      .fp   (ld_cvt)
    );

    qps_fp2int u_st (
      .fp   (s1_q.fp[l*FP_W +: FP_W]),
      .wide (s1_q.wide),
      .sgn  (s1_q.sgn),
      .scale(s1_scale),
      .val  (st_cvt)
    );

    if (l == 0) begin : g_first
      assign ld_fp[l] = ld_cvt;
      assign st_el[l] = st_cvt;
    end else begin : g_rest
      assign ld_fp[l] = s1_q.pair ? ld_cvt : FP_ONE;
      assign st_el[l] = s1_q.pair ? st_cvt : '0;
    end

    assign fp_pk[l*FP_W +: FP_W] = ld_fp[l];
  end

  always_comb begin
    mem_pk = '0;
    for (int l = 0; l < LANES; l++) begin
      if (s1_q.wide) mem_pk[l*ELEM_W +: ELEM_W] = st_el[l];
      else           mem_pk[l*HALF_W +: HALF_W] = st_el[l][HALF_W-1:0];
    end
    bytes_c = BYTES_W'((s1_q.wide ? 2 : 1) * (s1_q.pair ? LANES : 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v     <= 1'b0;
      s2_store <= 1'b0;
      s2_bytes <= '0;
      s2_fp    <= '0;
      s2_mem   <= '0;
    end else if (s2_rdy) begin
      s2_v <= s1_v;
      if (s1_v) begin
        s2_store <= s1_q.store;
        s2_bytes <= bytes_c;
        s2_fp    <= s1_q.store ? '0 : fp_pk;
        s2_mem   <= s1_q.store ? mem_pk : '0;
      end
    end
  end

  assign rsp_valid = s2_v;
  assign rsp_store = s2_store;
  assign rsp_bytes = s2_bytes;
  assign rsp_fp0   = s2_fp[FP_W-1:0];
  assign rsp_fp1   = s2_fp[2*FP_W-1:FP_W];
  assign rsp_mem   = s2_mem;
endmodule

// File: rtl/qps_convert_chk.sv
module qps_convert_chk
  import qps_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_store,
  input logic [BYTES_W-1:0] rsp_bytes,
  input logic [FP_W-1:0]    rsp_fp0,
  input logic [FP_W-1:0]    rsp_fp1,
  input logic [MEM_W-1:0]   rsp_mem
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_mem) && $stable(rsp_fp0)
      && $stable(rsp_fp1) && $stable(rsp_bytes) && $stable(rsp_store));

  // R1
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> req_ready);

  // R2
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready ##1 rsp_ready) |=> rsp_valid);

  // R10
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_bytes) == 1 && rsp_bytes <= BYTES_W'(LANES * ELEM_W / 8));

  // R11
  idle_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_store ? (rsp_fp0 == '0 && rsp_fp1 == '0) : (rsp_mem == '0)));
endmodule

bind qps_convert qps_convert_chk u_chk (.*);

// File: tb/qps_convert_test.sv
module qps_convert_test;
  import qps_pkg::*;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_ready, req_store, req_pair, rsp_valid, rsp_ready, rsp_store;
  logic [1:0]  req_kind;
  logic [5:0]  req_scale;
  logic [31:0] req_mem, req_fp0, req_fp1, rsp_fp0, rsp_fp1, rsp_mem;
  logic [2:0]  rsp_bytes;

  qps_convert uut (.*);

  typedef struct {
    logic store; logic [1:0] kind; logic [5:0] scale; logic pair;
    logic [31:0] mem, f0, f1; string tag;
  } stim_t;
  typedef struct {
    logic store; logic [2:0] bytes; logic [31:0] f0, f1, mem; int cyc; string tag;
  } exp_t;

  stim_t sq[$];
  exp_t  eq[$];
  int vectors = 0, fails = 0, cyc = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic real pow2(int s);
    real r = 1.0;
    if (s >= 0) for (int i = 0; i < s; i++) r = r * 2.0;
    else        for (int i = 0; i < -s; i++) r = r / 2.0;
    return r;
  endfunction

  function automatic logic [31:0] to_single(real r);
    logic [63:0] b;
    int e;
    if (r == 0.0) return 32'h0;
    b = $realtobits(r);
    e = int'(b[62:52]) - 1023 + 127;
    return {b[63], 8'(e), b[51:29]};
  endfunction

  function automatic real from_single(logic [31:0] f);
    logic [63:0] b;
    if (f[30:23] == 8'h00) return 0.0;
    b = {f[31], 11'(int'(f[30:23]) - 127 + 1023), f[22:0], 29'h0};
    return $bitstoreal(b);
  endfunction

  function automatic int elem_val(logic [31:0] mem, logic [1:0] kind, int idx);
    int v;
    if (kind[1]) begin
      v = int'(mem[idx*16 +: 16]);
      if (kind[0] && v >= 32768) v -= 65536;
    end else begin
      v = int'(mem[idx*8 +: 8]);
      if (kind[0] && v >= 128) v -= 256;
    end
    return v;
  endfunction

  function automatic logic [31:0] ld_exp(int v, int s);
    if (v == 0) return 32'h0;
    return to_single(real'(v) * pow2(-s));
  endfunction

  function automatic int st_exp(logic [31:0] f, logic [1:0] kind, int s);
    int lo, hi;
    real r;
    if (kind[1]) begin lo = kind[0] ? -32768 : 0; hi = kind[0] ? 32767 : 65535; end
    else         begin lo = kind[0] ? -128 : 0;   hi = kind[0] ? 127 : 255;     end
    if (f[30:23] == 8'hFF) return (f[22:0] != 0) ? 0 : (f[31] ? lo : hi);
    r = from_single(f) * pow2(s);
    if (r > real'(hi)) return hi;
    if (r < real'(lo)) return lo;
    return $rtoi(r);
  endfunction

  function automatic exp_t predict(stim_t t, int c);
    exp_t e;
    int s, r0, r1;
    s = int'($signed(t.scale));
    e.store = t.store; e.cyc = c; e.tag = t.tag;
    e.bytes = 3'((t.kind[1] ? 2 : 1) * (t.pair ? 2 : 1));
    if (t.store) begin
      r0 = st_exp(t.f0, t.kind, s);
      r1 = t.pair ? st_exp(t.f1, t.kind, s) : 0;
      e.mem = t.kind[1] ? {16'(r1), 16'(r0)} : {16'h0, 8'(r1), 8'(r0)};
      e.f0 = 0; e.f1 = 0;
    end else begin
      e.f0 = ld_exp(elem_val(t.mem, t.kind, 0), s);
      e.f1 = t.pair ? ld_exp(elem_val(t.mem, t.kind, 1), s) : 32'h3F80_0000;
      e.mem = 0;
    end
    return e;
  endfunction

  task automatic add(logic st, logic [1:0] k, int s, logic p, logic [31:0] m,
                     logic [31:0] a, logic [31:0] b, string tag);
    stim_t t;
    t.store = st; t.kind = k; t.scale = 6'(s); t.pair = p;
    t.mem = m; t.f0 = a; t.f1 = b; t.tag = tag;
    sq.push_back(t);
  endtask

  function automatic logic [31:0] rnd_float();
    int sel = $urandom_range(19);
    if (sel == 0) return 32'h7FC0_0000;
    if (sel == 1) return {$urandom_range(1), 8'hFF, 23'h0};
    if (sel == 2) return {$urandom_range(1), 8'h00, 23'($urandom)};
    return {1'($urandom_range(1)), 8'($urandom_range(150, 100)), 23'($urandom)};
  endfunction

  task automatic run(int valid_pct, int ready_pct, bit free);
    bit held = 0;
    logic [31:0] h_f0, h_f1, h_mem;
    int guard = 0;
    while ((sq.size() > 0 || eq.size() > 0) && guard < 20000) begin
      guard++;
      @(negedge clk);
      if (held) begin
        chk("R1", "held valid", 32'(rsp_valid), 32'd1);
        chk("R1", "held mem", rsp_mem, h_mem);
        chk("R1", "held fp0", rsp_fp0, h_f0);
        chk("R1", "held fp1", rsp_fp1, h_f1);
      end
      req_valid = (sq.size() > 0) && ($urandom_range(99) < valid_pct);
      if (req_valid) begin
        req_store = sq[0].store; req_kind = sq[0].kind; req_scale = sq[0].scale;
        req_pair = sq[0].pair; req_mem = sq[0].mem; req_fp0 = sq[0].f0; req_fp1 = sq[0].f1;
      end
      rsp_ready = ($urandom_range(99) < ready_pct);
      #1;
      if (free && rsp_ready) chk("R1", "ready at full rate", 32'(req_ready), 32'd1);
      if (req_valid && req_ready) eq.push_back(predict(sq.pop_front(), cyc));
      if (rsp_valid && rsp_ready) begin
        if (eq.size() == 0) begin
          chk("R1", "unexpected response", 32'd1, 32'd0);
        end else begin
          exp_t e = eq.pop_front();
          chk("R11", "store flag", 32'(rsp_store), 32'(e.store));
          chk("R10", "bytes", 32'(rsp_bytes), 32'(e.bytes));
          chk(e.tag, "fp0", rsp_fp0, e.f0);
          chk(e.tag, "fp1", rsp_fp1, e.f1);
          chk(e.tag, "mem", rsp_mem, e.mem);
          if (free) chk("R2", "latency", 32'(cyc - e.cyc), 32'd2);
        end
      end
      held = rsp_valid && !rsp_ready;
      h_f0 = rsp_fp0; h_f1 = rsp_fp1; h_mem = rsp_mem;
      cyc++;
    end
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; req_valid = 0; rsp_ready = 0; req_store = 0; req_kind = 0;
    req_scale = 0; req_pair = 0; req_mem = 0; req_fp0 = 0; req_fp1 = 0;
    repeat (3) @(negedge clk);
    chk("R12", "valid in reset", 32'(rsp_valid), 32'd0);
    chk("R12", "ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R12", "valid after reset", 32'(rsp_valid), 32'd0);
    chk("R12", "ready after reset", 32'(req_ready), 32'd1);

    // loads: lane order, signs, scaling
    add(0, 2'b00, 0,   1, 32'h0000_0503, 0, 0, "R5");
    add(0, 2'b01, 2,   1, 32'h0000_7F80, 0, 0, "R3");
    add(0, 2'b10, -3,  1, 32'h0001_FFFF, 0, 0, "R5");
    add(0, 2'b11, 31,  1, 32'h7FFF_8000, 0, 0, "R3");
    add(0, 2'b11, -32, 1, 32'h8001_7FFF, 0, 0, "R3");
    add(0, 2'b01, -5,  1, 32'h0000_FF01, 0, 0, "R3");
    // zero elements
    add(0, 2'b11, -32, 1, 32'h0000_0000, 0, 0, "R4");
    add(0, 2'b00, 31,  1, 32'h0000_0000, 0, 0, "R4");
    // single mode
    add(0, 2'b00, 0,   0, 32'h1234_5678, 0, 0, "R6");
    add(0, 2'b11, 1,   0, 32'h1234_C000, 0, 0, "R6");
    add(1, 2'b11, 0,   0, 32'h0, 32'h4040_0000, 32'h4040_0000, "R6");
    add(1, 2'b00, 0,   0, 32'h0, 32'h4040_0000, 32'h4040_0000, "R6");
    // truncation toward zero
    add(1, 2'b01, 0,   1, 0, 32'h4030_0000, 32'hC030_0000, "R7");
    add(1, 2'b01, 2,   1, 0, 32'h3F40_0000, 32'hBFD9_999A, "R7");
    add(1, 2'b10, 4,   1, 0, 32'h4040_0000, 32'h3F80_0000, "R7");
    add(1, 2'b11, -1,  1, 0, 32'h3F80_0000, 32'hBF80_0000, "R7");
    // saturation
    add(1, 2'b01, 0,   1, 0, 32'h4348_0000, 32'hC348_0000, "R8");
    add(1, 2'b00, 0,   1, 0, 32'hBF80_0000, 32'h437F_E666, "R8");
    add(1, 2'b10, 0,   1, 0, 32'h4974_2400, 32'hC974_2400, "R8");
    add(1, 2'b11, 0,   1, 0, 32'h7F80_0000, 32'hFF80_0000, "R8");
    add(1, 2'b11, 31,  1, 0, 32'h3F80_0000, 32'hBF80_0000, "R8");
    add(1, 2'b01, 7,   1, 0, 32'h3F80_0000, 32'hBF80_0000, "R8");
    // NaN, zero, denormal
    add(1, 2'b11, 0,   1, 0, 32'h7FC0_0000, 32'hFFC0_0001, "R9");
    add(1, 2'b01, 20,  1, 0, 32'h0000_0123, 32'h8000_0000, "R9");
    add(1, 2'b10, 0,   1, 0, 32'h0000_0000, 32'h807F_FFFF, "R9");
    run(100, 100, 1);

    // random traffic with back-pressure
    for (int i = 0; i < 400; i++) begin
      logic st = 1'($urandom_range(1));
      add(st, 2'($urandom_range(3)), $urandom_range(63) - 32, 1'($urandom_range(1)),
          $urandom, rnd_float(), rnd_float(), st ? "R7" : "R3");
    end
    run(70, 55, 0);

    // back-to-back at full rate
    for (int i = 0; i < 200; i++) begin
      logic st = 1'($urandom_range(1));
      add(st, 2'($urandom_range(3)), $urandom_range(63) - 32, 1'($urandom_range(1)),
          $urandom, rnd_float(), rnd_float(), st ? "R8" : "R3");
    end
    run(100, 100, 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule